// File: doc/BRIEF.md
# Paged Indirect Register Access Sequencer

This block lets a controller reach the wide registers of a device that can only be addressed through a window of 16-bit management registers at one fixed bus address. A single request names a page, a register offset, a width (8, 16, 32, 48 or 64 bits), a direction and, for writes, the value. The sequencer expands it into a run of 16-bit command-port transactions. These select the page, load or unload a bank of four consecutive data registers, launch the access with a command word, and poll that command word until the device clears its busy bits.

The command port is a plain single-outstanding handshake that a separate MDIO frame engine serves. The sequencer remembers which page it last selected and skips the page write when the page has not changed. It polls a bounded number of times with a fixed idle gap between polls. It returns one response pulse carrying an error flag and the reassembled read data.

Top module: `paged_reg_seq`

## Requirements
- R1: After reset `req_ready` is 1, `cmd_valid` and `rsp_done` are 0, and the remembered page is 0xFF, so the first request always selects its page.
- R2: A page select writes register 16 (0x10) with the page in bits 15:8, bits 7:1 zero and bit 0 set. It is issued only when the requested page differs from the remembered page.
- R3: The remembered page takes the new value only when the page write completes without a command error.
- R4: A write loads data registers 0x18, 0x19, 0x1A and 0x1B in ascending order, lowest word of `req_wdata` first. The word count by `req_width` code is: 0 (8-bit) and 1 (16-bit) load 1 word, 2 (32-bit) loads 2, 3 (48-bit) loads 3, and 4 to 7 load 4 (64-bit). An 8-bit write sends bits 15:8 as zero. The data loads are followed by the page select if needed, then a write of 0x11 with the offset in bits 15:8, bits 7:2 zero and bits 1:0 = 01.
- R5: A read issues the page select if needed, then writes 0x11 with the offset in bits 15:8 and bits 1:0 = 10, polls, and then reads the data registers from 0x18 upward, with the same word count as R4.
- R6: Each poll reads 0x11. The access is complete when bits 1:0 read 00. Between polls `cmd_valid` stays low for exactly POLL_GAP cycles (default 4). If bits 1:0 are still non-zero on the fifth poll, the response carries the error flag and no further transaction is issued.
- R7: Read data is packed with register 0x18 in bits 15:0, 0x19 in 31:16, and so on. Bits above the width are zero, and an 8-bit read keeps only bits 7:0 of 0x18.
- R8: A command error on any transaction ends the sequence at once. The response then has the error flag set and `rsp_rdata` zero.
- R9: A request is taken when `req_valid` and `req_ready` are both high, and `req_ready` is high only while idle. Request inputs are ignored while busy. `rsp_done` is a one-cycle pulse, and a write returns `rsp_rdata` zero.
- R10: `cmd_valid` stays high with `cmd_write`, `cmd_regnum` and `cmd_wdata` held until the cycle `cmd_done` is seen. `cmd_phy` is fixed at PHY_ADDR (default 30).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken this cycle if valid |
| req_page | input | 8 | Target page |
| req_ofs | input | 8 | Register offset within the page |
| req_width | input | 3 | Width code (0:8, 1:16, 2:32, 3:48, others:64) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 64 | Write value |
| rsp_done | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Response carries a failure |
| rsp_rdata | output | 64 | Read value, zero-extended |
| cmd_valid | output | 1 | Command-port transaction pending |
| cmd_write | output | 1 | 1 = register write, 0 = register read |
| cmd_phy | output | 5 | Fixed management bus address |
| cmd_regnum | output | 5 | Management register number |
| cmd_wdata | output | 16 | Register write value |
| cmd_done | input | 1 | Transaction finished this cycle |
| cmd_err | input | 1 | Transaction failed, valid with cmd_done |
| cmd_rdata | input | 16 | Register read value, valid with cmd_done |

## Verification
The poll that finds the busy bits cleared and the poll-limit decision can fall on the same transaction. On the fifth poll, a clear status must win and the sequence continues. A still-busy status on that same poll must end it with an error. A device stub in the bench keeps the command bits set for a chosen number of polls, and the cases of four and five busy polls are run back to back. Each is judged on the error flag, the read data, the full logged transaction list and the number of idle gap cycles between polls.

// File: rtl/preg_pkg.sv
package preg_pkg;

  localparam int REG_NUM_W = 5;

  localparam logic [REG_NUM_W-1:0] REG_PAGE  = 5'h10;
  localparam logic [REG_NUM_W-1:0] REG_CMD   = 5'h11;
  localparam logic [REG_NUM_W-1:0] REG_DATA0 = 5'h18;

  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] OP_RD = 2'b10;

  localparam logic [2:0] WCODE_8 = 3'd0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WDATA,
    ST_PAGE,
    ST_ADDR,
    ST_POLL,
    ST_WAIT,
    ST_RDATA,
    ST_RESP
  } seq_state_e;

  // number of 16-bit data registers touched for a width code
  function automatic logic [2:0] words_for(input logic [2:0] code);
    case (code)
      3'd0, 3'd1: return 3'd1;
      3'd2:       return 3'd2;
      3'd3:       return 3'd3;
      default:    return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/preg_rst_sync.sv
module preg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/preg_page_cache.sv
module preg_page_cache #(
  parameter int          PAGE_W    = 8,
  parameter logic [PAGE_W-1:0] IDLE_PAGE = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [PAGE_W-1:0] upd_page,
  input  logic [PAGE_W-1:0] cmp_page,
  output logic              page_hit,
  output logic [PAGE_W-1:0] cur_page
);
  logic [PAGE_W-1:0] page_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      page_q <= IDLE_PAGE;
    else if (upd_en) page_q <= upd_page;
  end

  assign cur_page = page_q;
  assign page_hit = (cmp_page == page_q);
endmodule

// File: rtl/preg_word_path.sv
module preg_word_path
  import preg_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int MAX_WORDS = 4,
  localparam int IDX_W    = $clog2(MAX_WORDS),
  localparam int CNT_W    = IDX_W + 1,
  localparam int DATA_W   = WORD_W * MAX_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [2:0]        width_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic [IDX_W-1:0]  word_idx,
  input  logic              cap_en,
  input  logic [WORD_W-1:0] cap_word,
  output logic [WORD_W-1:0] wr_word,
  output logic              word_last,
  output logic [DATA_W-1:0] rbuf
);
  logic [2:0]        width_q;
  logic [CNT_W-1:0]  nwords;
  logic [WORD_W-1:0] wr_lane [MAX_WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       width_q <= 3'd0;
    else if (load_en) width_q <= width_in;
  end

  assign nwords    = CNT_W'(words_for(width_q));
  assign word_last = (CNT_W'(word_idx) == (nwords - CNT_W'(1)));
  assign wr_word   = wr_lane[word_idx];

  for (genvar g = 0; g < MAX_WORDS; g++) begin : g_lane
    logic [WORD_W-1:0] wq, rq;
    logic [WORD_W-1:0] w_in, r_in;
    logic              hit;

    // lane 0 carries only a byte for the narrowest width, both directions
    if (g == 0) begin : g_low
      assign w_in = (width_in == WCODE_8) ? {{(WORD_W-8){1'b0}}, wdata_in[7:0]}
                                          : wdata_in[WORD_W-1:0];
      assign r_in = (width_q == WCODE_8) ? {{(WORD_W-8){1'b0}}, cap_word[7:0]}
                                         : cap_word;
    end else begin : g_up
      assign w_in = wdata_in[g*WORD_W +: WORD_W];
      assign r_in = cap_word;
    end

    assign hit = cap_en && (word_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       wq <= '0;
      else if (load_en) wq <= w_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rq <= '0;
      else if (load_en) rq <= '0;
      else if (hit)     rq <= r_in;
    end

    assign wr_lane[g]               = wq;
    assign rbuf[g*WORD_W +: WORD_W] = rq;
  end

  // R7: a byte-wide read never leaves anything above bit 7
  assert_byte_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (width_q == WCODE_8 && !load_en) |=> (rbuf[DATA_W-1:8] == '0));
endmodule

// File: rtl/preg_seq_fsm.sv
module preg_seq_fsm
  import preg_pkg::*;
#(
  parameter int PAGE_W     = 8,
  parameter int OFS_W      = 8,
  parameter int WORD_W     = 16,
  parameter int IDX_W      = 2,
  parameter int POLL_LIMIT = 5,
  parameter int POLL_GAP   = 4,
  localparam int POLL_CW   = $clog2(POLL_LIMIT + 1),
  localparam int GAP_CW    = $clog2(POLL_GAP + 2),
  localparam logic [POLL_CW-1:0] POLL_LAST = POLL_CW'(POLL_LIMIT - 1),
  localparam logic [GAP_CW-1:0]  GAP_LAST  = GAP_CW'((POLL_GAP > 0) ? POLL_GAP - 1 : 0)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [PAGE_W-1:0]    req_page,
  input  logic [OFS_W-1:0]     req_ofs,
  input  logic                 req_write,
  input  logic                 page_hit,
  output logic [PAGE_W-1:0]    cmp_page,
  output logic                 cache_upd,
  output logic [PAGE_W-1:0]    upd_page,
  input  logic                 word_last,
  input  logic [WORD_W-1:0]    wr_word,
  output logic [IDX_W-1:0]     word_idx,
  output logic                 load_en,
  output logic                 cap_en,
  output logic                 cmd_valid,
  output logic                 cmd_write,
  output logic [REG_NUM_W-1:0] cmd_regnum,
  output logic [WORD_W-1:0]    cmd_wdata,
  input  logic                 cmd_done,
  input  logic                 cmd_err,
  input  logic [1:0]           cmd_status,
  output logic                 rsp_done,
  output logic                 rsp_err
);
  seq_state_e         state_q, state_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [POLL_CW-1:0] poll_q, poll_d;
  logic [GAP_CW-1:0]  gap_q, gap_d;
  logic               err_q, err_d;
  logic [PAGE_W-1:0]  page_q;
  logic [OFS_W-1:0]   ofs_q;
  logic               wr_q;
  logic [WORD_W-1:0]  page_word, addr_word;

  assign page_word = {page_q, {(WORD_W-PAGE_W-1){1'b0}}, 1'b1};
  assign addr_word = {ofs_q, {(WORD_W-OFS_W-2){1'b0}}, (wr_q ? OP_WR : OP_RD)};

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_done  = (state_q == ST_RESP);
  assign rsp_err   = rsp_done && err_q;
  assign cmp_page  = (state_q == ST_IDLE) ? req_page : page_q;
  assign upd_page  = page_q;
  assign word_idx  = idx_q;

  always_comb begin
    state_d    = state_q;
    idx_d      = idx_q;
    poll_d     = poll_q;
    gap_d      = gap_q;
    err_d      = err_q;
    load_en    = 1'b0;
    cap_en     = 1'b0;
    cache_upd  = 1'b0;
    cmd_valid  = 1'b0;
    cmd_write  = 1'b0;
    cmd_regnum = REG_CMD;
    cmd_wdata  = '0;

    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          load_en = 1'b1;
          idx_d   = '0;
          poll_d  = '0;
          err_d   = 1'b0;
          if (req_write)     state_d = ST_WDATA;
          else if (page_hit) state_d = ST_ADDR;
          else               state_d = ST_PAGE;
        end
      end

      ST_WDATA: begin
        cmd_valid  = 1'b1;
        cmd_write  = 1'b1;
        cmd_regnum = REG_DATA0 + REG_NUM_W'(idx_q);
        cmd_wdata  = wr_word;
        if (cmd_done) begin
          if (cmd_err) begin
            err_d   = 1'b1;
            state_d = ST_RESP;
          end else if (word_last) begin
            state_d = page_hit ? ST_ADDR : ST_PAGE;
          end else begin
            idx_d = idx_q + IDX_W'(1);
          end
        end
      end

      ST_PAGE: begin
        cmd_valid  = 1'b1;
        cmd_write  = 1'b1;
        cmd_regnum = REG_PAGE;
        cmd_wdata  = page_word;
        if (cmd_done) begin
          if (cmd_err) begin
            err_d   = 1'b1;
            state_d = ST_RESP;
          end else begin
            cache_upd = 1'b1;
            state_d   = ST_ADDR;
          end
        end
      end

      ST_ADDR: begin
        cmd_valid  = 1'b1;
        cmd_write  = 1'b1;
        cmd_regnum = REG_CMD;
        cmd_wdata  = addr_word;
        if (cmd_done) begin
          if (cmd_err) begin
            err_d   = 1'b1;
            state_d = ST_RESP;
          end else begin
            poll_d  = '0;
            state_d = ST_POLL;
          end
        end
      end

      ST_POLL: begin
        cmd_valid  = 1'b1;
        cmd_regnum = REG_CMD;
        if (cmd_done) begin
          if (cmd_err) begin
            err_d   = 1'b1;
            state_d = ST_RESP;
          end else if (cmd_status == 2'b00) begin
            idx_d   = '0;
            state_d = wr_q ? ST_RESP : ST_RDATA;
          end else if (poll_q == POLL_LAST) begin
            err_d   = 1'b1;
            state_d = ST_RESP;
          end else begin
            poll_d  = poll_q + POLL_CW'(1);
            gap_d   = '0;
            state_d = (POLL_GAP == 0) ? ST_POLL : ST_WAIT;
          end
        end
      end

      ST_WAIT: begin
        gap_d = gap_q + GAP_CW'(1);
        if (gap_q == GAP_LAST) state_d = ST_POLL;
      end

      ST_RDATA: begin
        cmd_valid  = 1'b1;
        cmd_regnum = REG_DATA0 + REG_NUM_W'(idx_q);
        if (cmd_done) begin
          if (cmd_err) begin
            err_d   = 1'b1;
            state_d = ST_RESP;
          end else begin
            cap_en = 1'b1;
            if (word_last) state_d = ST_RESP;
            else           idx_d   = idx_q + IDX_W'(1);
          end
        end
      end

      ST_RESP: state_d = ST_IDLE;

      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      poll_q  <= '0;
      gap_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      poll_q  <= poll_d;
      gap_q   <= gap_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      ofs_q  <= '0;
      wr_q   <= 1'b0;
    end else if (load_en) begin
      page_q <= req_page;
      ofs_q  <= req_ofs;
      wr_q   <= req_write;
    end
  end

  // R10: a pending transaction is held unchanged until it is answered
  assert_cmd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_done) |=>
      (cmd_valid && $stable(cmd_regnum) && $stable(cmd_wdata) && $stable(cmd_write)));

  // R9: the response is a single pulse followed by idle
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> (!rsp_done && req_ready));

  // R9: nothing is in flight while a new request can be taken
  assert_ready_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!cmd_valid && !rsp_done));

  // R6: a busy answer to the last permitted poll ends in a failed response
  assert_poll_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_POLL && cmd_done && !cmd_err && cmd_status != 2'b00 && poll_q == POLL_LAST)
      |=> (rsp_done && rsp_err));

  // R8: a failed transaction is never followed by another one
  assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_done && cmd_err) |=> (rsp_done && rsp_err && !cmd_valid));
endmodule

// File: rtl/paged_reg_seq.sv
module paged_reg_seq
  import preg_pkg::*;
#(
  parameter int PAGE_W     = 8,
  parameter int OFS_W      = 8,
  parameter int WORD_W     = 16,
  parameter int MAX_WORDS  = 4,
  parameter int POLL_LIMIT = 5,
  parameter int POLL_GAP   = 4,
  parameter logic [4:0] PHY_ADDR = 5'd30,
  parameter logic [PAGE_W-1:0] IDLE_PAGE = '1,
  localparam int IDX_W  = $clog2(MAX_WORDS),
  localparam int DATA_W = WORD_W * MAX_WORDS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [PAGE_W-1:0]    req_page,
  input  logic [OFS_W-1:0]     req_ofs,
  input  logic [2:0]           req_width,
  input  logic                 req_write,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 rsp_done,
  output logic                 rsp_err,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic                 cmd_valid,
  output logic                 cmd_write,
  output logic [4:0]           cmd_phy,
  output logic [REG_NUM_W-1:0] cmd_regnum,
  output logic [WORD_W-1:0]    cmd_wdata,
  input  logic                 cmd_done,
  input  logic                 cmd_err,
  input  logic [WORD_W-1:0]    cmd_rdata
);
  logic              rst_s_n;
  logic              page_hit, cache_upd, load_en, cap_en, word_last;
  logic [PAGE_W-1:0] cmp_page, upd_page, cur_page;
  logic [IDX_W-1:0]  word_idx;
  logic [WORD_W-1:0] wr_word;
  logic [DATA_W-1:0] rbuf;

  preg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  preg_page_cache #(.PAGE_W(PAGE_W), .IDLE_PAGE(IDLE_PAGE)) u_cache (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .upd_en   (cache_upd),
    .upd_page (upd_page),
    .cmp_page (cmp_page),
    .page_hit (page_hit),
    .cur_page (cur_page)
  );

  preg_word_path #(.WORD_W(WORD_W), .MAX_WORDS(MAX_WORDS)) u_words (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .load_en   (load_en),
    .width_in  (req_width),
    .wdata_in  (req_wdata),
    .word_idx  (word_idx),
    .cap_en    (cap_en),
    .cap_word  (cmd_rdata),
    .wr_word   (wr_word),
    .word_last (word_last),
    .rbuf      (rbuf)
  );

  preg_seq_fsm #(
    .PAGE_W(PAGE_W), .OFS_W(OFS_W), .WORD_W(WORD_W), .IDX_W(IDX_W),
    .POLL_LIMIT(POLL_LIMIT), .POLL_GAP(POLL_GAP)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_page   (req_page),
    .req_ofs    (req_ofs),
    .req_write  (req_write),
    .page_hit   (page_hit),
    .cmp_page   (cmp_page),
    .cache_upd  (cache_upd),
    .upd_page   (upd_page),
    .word_last  (word_last),
    .wr_word    (wr_word),
    .word_idx   (word_idx),
    .load_en    (load_en),
    .cap_en     (cap_en),
    .cmd_valid  (cmd_valid),
    .cmd_write  (cmd_write),
    .cmd_regnum (cmd_regnum),
    .cmd_wdata  (cmd_wdata),
    .cmd_done   (cmd_done),
    .cmd_err    (cmd_err),
    .cmd_status (cmd_rdata[1:0]),
    .rsp_done   (rsp_done),
    .rsp_err    (rsp_err)
  );

  assign cmd_phy   = PHY_ADDR;
  assign rsp_rdata = (rsp_done && !rsp_err) ? rbuf : '0;

  // R3: the remembered page moves only after an accepted page write
  assert_cache_update_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
    !$stable(cur_page) |->
      $past(cmd_valid && cmd_write && cmd_done && !cmd_err && cmd_regnum == REG_PAGE));

  // R2: a page select never repeats the page already selected
  assert_page_skip_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cmd_valid && cmd_regnum == REG_PAGE) |-> (cmd_wdata[WORD_W-1 -: PAGE_W] != cur_page));
endmodule

// File: tb/sim_paged_reg_seq.sv
module sim_paged_reg_seq;
  localparam int GAP = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_page = '0;
  logic [7:0]  req_ofs = '0;
  logic [2:0]  req_width = '0;
  logic        req_write = 1'b0;
  logic [63:0] req_wdata = '0;
  logic        rsp_done, rsp_err;
  logic [63:0] rsp_rdata;
  logic        cmd_valid, cmd_write;
  logic [4:0]  cmd_phy, cmd_regnum;
  logic [15:0] cmd_wdata;
  logic        cmd_done = 1'b0;
  logic        cmd_err = 1'b0;
  logic [15:0] cmd_rdata = '0;

  always #5 clk = ~clk;

  paged_reg_seq #(.POLL_GAP(GAP)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_page(req_page),
    .req_ofs(req_ofs), .req_width(req_width), .req_write(req_write),
    .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_phy(cmd_phy), .cmd_regnum(cmd_regnum), .cmd_wdata(cmd_wdata),
    .cmd_done(cmd_done), .cmd_err(cmd_err), .cmd_rdata(cmd_rdata)
  );

  int n_checks = 0;
  int n_errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- device stub behind the command port ----------------
  int          lat = 0;
  int          txn_idx = 0;
  int          err_at = -1;
  int          busy_cfg = 0;
  int          poll_left = 0;
  int          gap_cnt = 0;
  logic [1:0]  cmd_bits = '0;
  logic [7:0]  st_page = '0;
  logic [7:0]  st_ofs = '0;
  logic [15:0] st_d [4];
  logic [63:0] st_mem [logic [15:0]];
  logic [21:0] act_q [$];

  initial for (int i = 0; i < 4; i++) st_d[i] = '0;

  always @(posedge clk) begin
    if (rst_n && !cmd_valid && !rsp_done && !cmd_done && txn_idx > 0) gap_cnt++;
    if (cmd_done) begin
      cmd_done <= 1'b0;
      cmd_err  <= 1'b0;
      lat = 0;
    end else if (cmd_valid) begin
      if (lat < 1) lat++;
      else begin
        lat = 0;
        cmd_done <= 1'b1;
        act_q.push_back({cmd_write, cmd_regnum, cmd_write ? cmd_wdata : 16'h0});
        if (txn_idx == err_at) cmd_err <= 1'b1;
        else if (cmd_write) begin
          if (cmd_regnum == 5'h10 && cmd_wdata[0]) st_page = cmd_wdata[15:8];
          else if (cmd_regnum == 5'h11) begin
            st_ofs = cmd_wdata[15:8];
            cmd_bits = cmd_wdata[1:0];
            poll_left = busy_cfg;
            if (cmd_wdata[0]) st_mem[{st_page, st_ofs}] = {st_d[3], st_d[2], st_d[1], st_d[0]};
            if (cmd_wdata[1]) begin
              logic [63:0] v;
              v = st_mem.exists({st_page, st_ofs}) ? st_mem[{st_page, st_ofs}] : 64'h0;
              for (int i = 0; i < 4; i++) st_d[i] = v[i*16 +: 16];
            end
          end else if (cmd_regnum >= 5'h18) st_d[cmd_regnum - 5'h18] = cmd_wdata;
        end else begin
          if (cmd_regnum == 5'h11) begin
            cmd_rdata <= {st_ofs, 6'b0, (poll_left > 0) ? cmd_bits : 2'b00};
            if (poll_left > 0) poll_left--;
          end else if (cmd_regnum >= 5'h18) cmd_rdata <= st_d[cmd_regnum - 5'h18];
          else cmd_rdata <= 16'h0;
        end
        txn_idx++;
      end
    end
  end

  // ---------------- expectation model and scoreboard ----------------
  typedef struct {
    bit          err;
    logic [63:0] rdata;
    int          gap;
    string       req;
  } exp_t;

  exp_t        sb_q [$];
  logic [21:0] exp_tr [$];
  int          resp_seen = 0;
  int          exp_k = 0;
  logic [7:0]  m_cache = 8'hFF;
  logic [15:0] m_d [4];
  logic [63:0] m_mem [logic [15:0]];

  initial for (int i = 0; i < 4; i++) m_d[i] = '0;

  function automatic bit tstep(input logic [21:0] e, input int errat);
    exp_tr.push_back(e);
    exp_k++;
    return (exp_k - 1) != errat;
  endfunction

  task automatic run(input logic [7:0] page, input logic [7:0] ofs, input logic [2:0] wcode,
                     input bit wr, input logic [63:0] wdata, input int busy,
                     input int errat, input string req);
    exp_t e;
    bit ok = 1, fin = 0;
    int np = 0;
    int nw = (wcode <= 1) ? 1 : (wcode == 2) ? 2 : (wcode == 3) ? 3 : 4;
    logic [63:0] full;
    logic [63:0] wv = (wcode == 0) ? {56'h0, wdata[7:0]} : wdata;
    exp_k = 0;
    exp_tr.delete();
    if (wr) begin
      for (int i = 0; i < nw; i++) if (ok) begin
        ok = tstep({1'b1, 5'h18 + 5'(i), wv[i*16 +: 16]}, errat);
        if (ok) m_d[i] = wv[i*16 +: 16];
      end
    end
    if (ok && page != m_cache) begin
      ok = tstep({1'b1, 5'h10, page, 8'h01}, errat);
      if (ok) m_cache = page;
    end
    if (ok) begin
      ok = tstep({1'b1, 5'h11, ofs, wr ? 8'h01 : 8'h02}, errat);
      if (ok && wr) m_mem[{page, ofs}] = {m_d[3], m_d[2], m_d[1], m_d[0]};
      if (ok && !wr) begin
        full = m_mem.exists({page, ofs}) ? m_mem[{page, ofs}] : 64'h0;
        for (int i = 0; i < 4; i++) m_d[i] = full[i*16 +: 16];
      end
    end
    if (ok) for (int p = 0; p < 5; p++) begin
      ok = tstep({1'b0, 5'h11, 16'h0}, errat);
      np++;
      if (!ok) break;
      if (p >= busy) begin fin = 1; break; end
    end
    if (ok && fin && !wr)
      for (int i = 0; i < nw; i++) if (ok) ok = tstep({1'b0, 5'h18 + 5'(i), 16'h0}, errat);
    e.err = !(ok && fin);
    full = {m_d[3], m_d[2], m_d[1], m_d[0]};
    if (wr || e.err) e.rdata = 64'h0;
    else if (wcode == 0) e.rdata = {56'h0, full[7:0]};
    else if (nw == 4) e.rdata = full;
    else e.rdata = full & ((64'h1 << (16 * nw)) - 64'h1);
    e.gap = (np > 0) ? GAP * (np - 1) : 0;
    e.req = req;
    sb_q.push_back(e);

    @(negedge clk);
    busy_cfg = busy; err_at = errat; txn_idx = 0; gap_cnt = 0; act_q.delete();
    req_valid = 1'b1; req_page = page; req_ofs = ofs; req_width = wcode;
    req_write = wr; req_wdata = wdata;
    @(negedge clk);
    req_valid = 1'b0;
    // R9: fields changed while busy must not leak into the running request
    req_page = ~page; req_ofs = ~ofs; req_width = 3'd2; req_write = ~wr; req_wdata = ~wdata;
    chk(req_ready == 1'b0, "R9", "ready while busy", 64'(req_ready), 64'h0);
    begin
      int start = resp_seen;
      while (resp_seen == start) @(negedge clk);
    end
    @(negedge clk);
  endtask

  // monitor: pops expectations as responses appear
  always @(negedge clk) begin
    if (rst_n && rsp_done) begin
      exp_t e;
      bit same;
      if (sb_q.size() == 0) begin
        chk(1'b0, "R9", "unexpected response", 64'h1, 64'h0);
      end else begin
        e = sb_q.pop_front();
        chk(rsp_err == e.err, e.req, "error flag", 64'(rsp_err), 64'(e.err));
        chk(rsp_rdata == e.rdata, e.req, "read data", rsp_rdata, e.rdata);
        chk(gap_cnt == e.gap, "R6", "poll gap cycles", 64'(gap_cnt), 64'(e.gap));
        same = (act_q.size() == exp_tr.size());
        for (int i = 0; i < act_q.size() && same; i++) if (act_q[i] != exp_tr[i]) begin
          same = 0;
          $display("  transaction %0d: actual %0h expected %0h", i, act_q[i], exp_tr[i]);
        end
        chk(same, e.req, "transaction list length", 64'(act_q.size()), 64'(exp_tr.size()));
      end
      resp_seen++;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk(1'b0, "R9", "watchdog expired", 64'h0, 64'h1);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: quiet idle state after reset
    chk(req_ready == 1'b1, "R1", "ready after reset", 64'(req_ready), 64'h1);
    chk(cmd_valid == 1'b0, "R1", "no command after reset", 64'(cmd_valid), 64'h0);
    chk(rsp_done == 1'b0, "R1", "no response after reset", 64'(rsp_done), 64'h0);
    // R10: fixed bus address
    chk(cmd_phy == 5'd30, "R10", "bus address", 64'(cmd_phy), 64'd30);

    run(8'h03, 8'h20, 3'd1, 1, 64'h0000_0000_0000_BEEF, 0, -1, "R1");  // first page select
    run(8'h03, 8'h20, 3'd1, 0, 64'h0, 0, -1, "R2");                    // page skipped
    run(8'h03, 8'h30, 3'd4, 1, 64'h1122_3344_5566_7788, 2, -1, "R4");
    run(8'h03, 8'h30, 3'd4, 0, 64'h0, 4, -1, "R6");                    // clears on fifth poll
    run(8'h03, 8'h30, 3'd4, 0, 64'h0, 5, -1, "R6");                    // still busy on fifth
    run(8'h03, 8'h30, 3'd0, 0, 64'h0, 0, -1, "R7");                    // byte read
    run(8'h07, 8'h01, 3'd3, 1, 64'hAAAA_BBBB_CCCC_DDDD, 1, -1, "R4");
    run(8'h07, 8'h01, 3'd3, 0, 64'h0, 1, -1, "R5");
    run(8'h03, 8'h30, 3'd2, 0, 64'h0, 0, -1, "R7");                    // 32-bit read
    run(8'h09, 8'h05, 3'd2, 1, 64'h0000_0000_CAFE_F00D, 0, 2, "R8");   // page write fails
    run(8'h09, 8'h05, 3'd1, 0, 64'h0, 0, -1, "R3");                    // page select again
    run(8'h03, 8'h30, 3'd1, 0, 64'h0, 3, 2, "R8");                     // poll fails
    run(8'h03, 8'h30, 3'd6, 0, 64'h0, 0, -1, "R4");                    // code 6 acts as 64-bit
    run(8'h03, 8'h40, 3'd0, 1, 64'h0000_0000_0000_ABCD, 0, -1, "R4");  // byte write
    run(8'h03, 8'h40, 3'd1, 0, 64'h0, 0, -1, "R7");
    run(8'h03, 8'h30, 3'd4, 0, 64'h0, 0, 5, "R8");                     // last data read fails

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule